// File: doc/BRIEF.md
# Snooping Three-State Cache Line Controller

This block keeps coherence state for a small direct-mapped write-back cache that shares a snooping bus with other caches. Each line is Invalid, Shared (clean, read-only) or Exclusive (sole copy, writable, dirty). The CPU side presents one request at a time and holds it until acknowledged. Hits complete in the cycle they are presented. Misses raise a bus request and wait for the arbiter's grant. After the grant the block drives an optional write-back of a dirty victim, then a read-miss or write-miss command, and then waits for the fill data.

The block also watches the commands that other caches place on the bus. A snooped miss that names a line this cache holds dirty makes the controller return that line's data and raise an abort toward memory. A snooped write miss removes a clean copy. Line state is never changed for a CPU miss before the grant arrives. If a snoop alters the line that a waiting request targets, the request is dropped and evaluated again from the start. Every write to a line that is not Exclusive is handled as a miss, including a write to a Shared line with a matching tag.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, bus_req_o is low, bus_cmd_o is idle (00), cpu_ack_o is low and snp_abort_o is low.
- R2: A read to a Shared or Exclusive line with a matching tag, or a write to an Exclusive line with a matching tag, raises cpu_ack_o in the same cycle with no bus request. A read returns the line data; a write replaces it.
- R3: A read to an Invalid line raises bus_req_o in the next cycle. After grant it drives read miss (01) with the request address, then holds the bus until fill_valid_i. In the fill cycle it acknowledges with the fill data, and the line becomes Shared.
- R4: A write to an Invalid line, or to a Shared line with a matching tag, issues write miss (10) after grant. The line becomes Exclusive holding the CPU's write data.
- R5: A read whose tag differs from that of a Shared line issues a read miss with no write-back, and the line becomes Shared with the new tag and the fill data.
- R6: A read whose tag differs from that of an Exclusive line first drives write-back (11) in the cycle after grant, carrying the old address and dirty data. It then drives read miss, and the line ends Shared.
- R7: A write whose tag differs from that of an Exclusive line drives write-back of the old line, then write miss, and the line ends Exclusive with the new tag.
- R8: A snooped write miss whose address matches a Shared line makes that line Invalid without any abort.
- R9: A snooped read miss or write miss whose address matches an Exclusive line raises snp_abort_o in the next cycle, together with that address and the line's data. The line becomes Shared after a read miss and Invalid after a write miss.
- R10: Snooped idle (00) or write-back (11) commands, and misses whose tag does not match a valid line, leave all lines unchanged and do not raise snp_abort_o.
- R11: Until bus_gnt_i is seen, bus_cmd_o stays idle and the line a pending miss targets keeps its old state, tag and data.
- R12: When a snoop changes the line that a request waiting for grant targets, bus_req_o drops for one cycle and the request is evaluated again. A dirty victim that the snoop already supplied is not written back again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid_i | input | 1 | CPU request present, held until acknowledged |
| cpu_write_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Request address {tag, index} |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ack_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_ack_o on a read |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant, held while bus_req_o stays high |
| bus_cmd_o | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | ADDR_W | Address of the driven command |
| bus_data_o | output | DATA_W | Data of a write-back |
| fill_valid_i | input | 1 | Fill data for the outstanding miss is present |
| fill_data_i | input | DATA_W | Fill data |
| snp_cmd_i | input | 2 | Command seen on the bus from another cache, same encoding |
| snp_addr_i | input | ADDR_W | Address seen on the bus |
| snp_abort_o | output | 1 | Memory must abort; this cache supplies the block |
| snp_wb_addr_o | output | ADDR_W | Address of the supplied block |
| snp_wb_data_o | output | DATA_W | Data of the supplied block |

## Verification
A line left in the wrong state shows at the ports at the next access to that index. A stale Exclusive line acknowledges a write that should have gone to the bus. A line wrongly left Invalid raises a bus request where a same-cycle hit was due. A lost dirty bit shows as a missing write-back in the cycle after grant, or as a missing abort one cycle after a matching snoop. The bench keeps a reference of every line and of memory. It checks the bus command, address and data cycle by cycle through every miss, so a corrupt tag or datum is reported on the first transaction that exposes it.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHD = 2'b01,
        LN_EXC = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'b00,
        CMD_RDMISS = 2'b01,
        CMD_WRMISS = 2'b10,
        CMD_WBACK  = 2'b11
    } bus_cmd_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_WAIT,
        FS_WBACK,
        FS_MISS,
        FS_FILL
    } fsm_st_e;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cpu_we_i,
    input  logic [IDX_W-1:0]               cpu_idx_i,
    input  logic [1:0]                     cpu_st_i,
    input  logic [TAG_W-1:0]               cpu_tag_i,
    input  logic [DATA_W-1:0]              cpu_data_i,
    input  logic                           snp_we_i,
    input  logic [IDX_W-1:0]               snp_idx_i,
    input  logic [1:0]                     snp_st_i,
    output logic [LINES-1:0][1:0]          st_o,
    output logic [LINES-1:0][TAG_W-1:0]    tag_o,
    output logic [LINES-1:0][DATA_W-1:0]   data_o
);

    typedef struct packed {
        logic [LINES-1:0][1:0]        st;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] data;
    } store_t;

    store_t s_d, s_q;

    // CPU-side update first, snoop-side state update wins on the same line
    always_comb begin
        s_d = s_q;
        if (cpu_we_i) begin
            s_d.st[cpu_idx_i]   = cpu_st_i;
            s_d.tag[cpu_idx_i]  = cpu_tag_i;
            s_d.data[cpu_idx_i] = cpu_data_i;
        end
        if (snp_we_i) begin
            s_d.st[snp_idx_i] = snp_st_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o   = s_q.st;
    assign tag_o  = s_q.tag;
    assign data_o = s_q.data;

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en_i,
    input  logic [1:0]                  cmd_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [LINES-1:0][1:0]       st_i,
    input  logic [LINES-1:0][TAG_W-1:0] tag_i,
    output logic                        hit_o,
    output logic [IDX_W-1:0]            hit_idx_o,
    output logic                        upd_we_o,
    output logic [1:0]                  upd_st_o,
    output logic                        abort_o,
    output logic [IDX_W-1:0]            wb_idx_o,
    output logic [TAG_W-1:0]            wb_tag_o
);

    typedef struct packed {
        logic             abort;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } flush_t;

    flush_t f_d, f_q;

    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    logic [LINES-1:0] match;
    logic             is_miss;
    logic [1:0]       cur_st;

    assign s_idx   = addr_i[IDX_W-1:0];
    assign s_tag   = addr_i[ADDR_W-1:IDX_W];
    assign is_miss = (cmd_i == CMD_RDMISS) || (cmd_i == CMD_WRMISS);
    assign cur_st  = st_i[s_idx];

    // second read port on the tag array: one comparator per line
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = (tag_i[g] == s_tag) && (st_i[g] != LN_INV);
    end

    assign hit_o     = en_i && is_miss && match[s_idx];
    assign hit_idx_o = s_idx;

    always_comb begin
        upd_we_o = 1'b0;
        upd_st_o = cur_st;
        f_d      = '0;
        f_d.idx  = s_idx;
        f_d.tag  = s_tag;
        if (hit_o) begin
            if (cur_st == LN_EXC) begin
                f_d.abort = 1'b1;
                upd_we_o  = 1'b1;
                upd_st_o  = (cmd_i == CMD_RDMISS) ? LN_SHD : LN_INV;
            end else if (cmd_i == CMD_WRMISS) begin
                upd_we_o  = 1'b1;
                upd_st_o  = LN_INV;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign abort_o  = f_q.abort;
    assign wb_idx_o = f_q.idx;
    assign wb_tag_o = f_q.tag;

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid_i,
    input  logic              cpu_write_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ack_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  logic [1:0]        ln_st_i,
    input  logic [TAG_W-1:0]  ln_tag_i,
    input  logic [DATA_W-1:0] ln_data_i,
    input  logic              restart_i,
    input  logic              bus_gnt_i,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic              bus_req_o,
    output logic              bus_own_o,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              ln_we_o,
    output logic [1:0]        ln_st_o,
    output logic [TAG_W-1:0]  ln_tag_o,
    output logic [DATA_W-1:0] ln_data_o
);

    typedef struct packed {
        fsm_st_e st;
    } fsm_t;

    fsm_t r_d, r_q;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic             tag_eq;
    logic             hit;
    logic             victim_dirty;

    assign req_tag      = cpu_addr_i[ADDR_W-1:IDX_W];
    assign req_idx      = cpu_addr_i[IDX_W-1:0];
    assign tag_eq       = (ln_tag_i == req_tag);
    assign hit          = (ln_st_i != LN_INV) && tag_eq &&
                          (!cpu_write_i || (ln_st_i == LN_EXC));
    assign victim_dirty = (ln_st_i == LN_EXC) && !tag_eq;

    always_comb begin
        r_d         = r_q;
        cpu_ack_o   = 1'b0;
        cpu_rdata_o = ln_data_i;
        bus_req_o   = 1'b0;
        bus_own_o   = 1'b0;
        bus_cmd_o   = CMD_IDLE;
        bus_addr_o  = cpu_addr_i;
        bus_data_o  = '0;
        ln_we_o     = 1'b0;
        ln_st_o     = LN_EXC;
        ln_tag_o    = req_tag;
        ln_data_o   = cpu_wdata_i;
        unique case (r_q.st)
            FS_IDLE: begin
                if (cpu_valid_i) begin
                    if (hit) begin
                        cpu_ack_o = 1'b1;
                        ln_we_o   = cpu_write_i;
                    end else begin
                        r_d.st = FS_WAIT;
                    end
                end
            end
            FS_WAIT: begin
                bus_req_o = 1'b1;
                if (restart_i) begin
                    r_d.st = FS_IDLE;
                end else if (bus_gnt_i) begin
                    r_d.st = victim_dirty ? FS_WBACK : FS_MISS;
                end
            end
            FS_WBACK: begin
                bus_req_o  = 1'b1;
                bus_own_o  = 1'b1;
                bus_cmd_o  = CMD_WBACK;
                bus_addr_o = {ln_tag_i, req_idx};
                bus_data_o = ln_data_i;
                r_d.st     = FS_MISS;
            end
            FS_MISS: begin
                bus_req_o = 1'b1;
                bus_own_o = 1'b1;
                bus_cmd_o = cpu_write_i ? CMD_WRMISS : CMD_RDMISS;
                r_d.st    = FS_FILL;
            end
            FS_FILL: begin
                bus_req_o   = 1'b1;
                bus_own_o   = 1'b1;
                cpu_rdata_o = fill_data_i;
                if (fill_valid_i) begin
                    cpu_ack_o = 1'b1;
                    ln_we_o   = 1'b1;
                    ln_st_o   = cpu_write_i ? LN_EXC : LN_SHD;
                    ln_data_o = cpu_write_i ? cpu_wdata_i : fill_data_i;
                    r_d.st    = FS_IDLE;
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st <= FS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W  = $clog2(LINES),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid_i,
    input  logic              cpu_write_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ack_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_abort_o,
    output logic [ADDR_W-1:0] snp_wb_addr_o,
    output logic [DATA_W-1:0] snp_wb_data_o
);

    logic [LINES-1:0][1:0]        st_q;
    logic [LINES-1:0][TAG_W-1:0]  tag_q;
    logic [LINES-1:0][DATA_W-1:0] data_q;

    logic [IDX_W-1:0]  cpu_idx;
    logic              c_we;
    logic [1:0]        c_st;
    logic [TAG_W-1:0]  c_tag;
    logic [DATA_W-1:0] c_data;
    logic              s_we;
    logic [1:0]        s_st;
    logic              s_hit;
    logic [IDX_W-1:0]  s_idx;
    logic              own;
    logic              restart;
    logic              abort_q;
    logic [IDX_W-1:0]  wb_idx;
    logic [TAG_W-1:0]  wb_tag;

    assign cpu_idx = cpu_addr_i[IDX_W-1:0];
    assign restart = s_hit && (s_idx == cpu_idx);

    msi_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we_i  (c_we),
        .cpu_idx_i (cpu_idx),
        .cpu_st_i  (c_st),
        .cpu_tag_i (c_tag),
        .cpu_data_i(c_data),
        .snp_we_i  (s_we),
        .snp_idx_i (s_idx),
        .snp_st_i  (s_st),
        .st_o      (st_q),
        .tag_o     (tag_q),
        .data_o    (data_q)
    );

    msi_snoop_unit #(
        .LINES(LINES),
        .TAG_W(TAG_W)
    ) u_snoop (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (!own),
        .cmd_i    (snp_cmd_i),
        .addr_i   (snp_addr_i),
        .st_i     (st_q),
        .tag_i    (tag_q),
        .hit_o    (s_hit),
        .hit_idx_o(s_idx),
        .upd_we_o (s_we),
        .upd_st_o (s_st),
        .abort_o  (abort_q),
        .wb_idx_o (wb_idx),
        .wb_tag_o (wb_tag)
    );

    msi_req_fsm #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_valid_i (cpu_valid_i),
        .cpu_write_i (cpu_write_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_ack_o   (cpu_ack_o),
        .cpu_rdata_o (cpu_rdata_o),
        .ln_st_i     (st_q[cpu_idx]),
        .ln_tag_i    (tag_q[cpu_idx]),
        .ln_data_i   (data_q[cpu_idx]),
        .restart_i   (restart),
        .bus_gnt_i   (bus_gnt_i),
        .fill_valid_i(fill_valid_i),
        .fill_data_i (fill_data_i),
        .bus_req_o   (bus_req_o),
        .bus_own_o   (own),
        .bus_cmd_o   (bus_cmd_o),
        .bus_addr_o  (bus_addr_o),
        .bus_data_o  (bus_data_o),
        .ln_we_o     (c_we),
        .ln_st_o     (c_st),
        .ln_tag_o    (c_tag),
        .ln_data_o   (c_data)
    );

    assign snp_abort_o   = abort_q;
    assign snp_wb_addr_o = abort_q ? {wb_tag, wb_idx} : '0;
    assign snp_wb_data_o = abort_q ? data_q[wb_idx] : '0;

endmodule

// File: rtl/msi_cache_ctrl_chk.sv
module msi_cache_ctrl_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid_i,
    input logic              cpu_ack_o,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic [1:0]        bus_cmd_o,
    input logic [1:0]        snp_cmd_i,
    input logic [ADDR_W-1:0] snp_addr_i,
    input logic              snp_abort_o,
    input logic [ADDR_W-1:0] snp_wb_addr_o
);

    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack_o |-> cpu_valid_i); // R2

    AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != 2'b00) |-> bus_req_o); // R3

    AST_CMD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != 2'b00) |-> $past(bus_gnt_i)); // R11

    AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == 2'b11) |=> (bus_cmd_o == 2'b01 || bus_cmd_o == 2'b10)); // R6

    AST_MISS_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == 2'b01 || bus_cmd_o == 2'b10) |=> (bus_req_o && bus_cmd_o == 2'b00)); // R3

    AST_ABORT_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort_o |-> ($past(snp_cmd_i) == 2'b01 || $past(snp_cmd_i) == 2'b10)); // R9

    AST_ABORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort_o |-> (snp_wb_addr_o == $past(snp_addr_i))); // R9

endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid_i  (cpu_valid_i),
    .cpu_ack_o    (cpu_ack_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_cmd_o    (bus_cmd_o),
    .snp_cmd_i    (snp_cmd_i),
    .snp_addr_i   (snp_addr_i),
    .snp_abort_o  (snp_abort_o),
    .snp_wb_addr_o(snp_wb_addr_o)
);

// File: tb/msi_cache_ctrl_bench.sv
module msi_cache_ctrl_bench;

    localparam int LINES  = 4;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ack;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;
    logic [1:0]        snp_cmd = 2'b00;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_abort;
    logic [ADDR_W-1:0] snp_wb_addr;
    logic [DATA_W-1:0] snp_wb_data;

    msi_cache_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_msi_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
        .bus_addr_o(bus_addr), .bus_data_o(bus_data),
        .fill_valid_i(fill_valid), .fill_data_i(fill_data),
        .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr), .snp_abort_o(snp_abort),
        .snp_wb_addr_o(snp_wb_addr), .snp_wb_data_o(snp_wb_data)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // reference: 0 Invalid, 1 Shared, 2 Exclusive
    int                m_st [LINES];
    logic [TAG_W-1:0]  m_tag[LINES];
    logic [DATA_W-1:0] m_dat[LINES];
    logic [DATA_W-1:0] mem  [64];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string op_req(input bit wr, input logic [ADDR_W-1:0] a);
        int i = int'(a[IDX_W-1:0]);
        bit tm = (m_tag[i] == a[ADDR_W-1:IDX_W]);
        if (m_st[i] != 0 && tm && (!wr || m_st[i] == 2)) return "R2";
        if (m_st[i] == 2 && !tm) return wr ? "R7" : "R6";
        if (wr) return "R4";
        if (m_st[i] == 1) return "R5";
        return "R3";
    endfunction

    task automatic cpu_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          input int gdly, input int fdly);
        int i = int'(a[IDX_W-1:0]);
        logic [TAG_W-1:0] tg = a[ADDR_W-1:IDX_W];
        string rq = op_req(wr, a);
        bit dirty = (m_st[i] == 2) && (m_tag[i] != tg);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (rq == "R2") begin
            chk(rq, "hit ack", cpu_ack, 1);
            chk(rq, "hit no bus_req", bus_req, 0);
            if (!wr) chk(rq, "hit rdata", cpu_rdata, m_dat[i]);
            else m_dat[i] = wd;
        end else begin
            chk(rq, "miss no ack", cpu_ack, 0);
            for (int k = 0; k < gdly; k++) begin
                @(negedge clk); #1;
                chk("R11", "req while waiting", bus_req, 1);
                chk("R11", "cmd idle before grant", bus_cmd, 0);
            end
            @(negedge clk);
            bus_gnt = 1'b1;
            #1;
            chk(rq, "req at grant", bus_req, 1);
            chk("R11", "cmd idle at grant", bus_cmd, 0);
            if (dirty) begin
                @(negedge clk); #1;
                chk(rq, "write-back cmd", bus_cmd, 3);
                chk(rq, "write-back addr", bus_addr, {m_tag[i], a[IDX_W-1:0]});
                chk(rq, "write-back data", bus_data, m_dat[i]);
                mem[{m_tag[i], a[IDX_W-1:0]}] = m_dat[i];
            end
            @(negedge clk); #1;
            chk(rq, "miss cmd", bus_cmd, wr ? 2 : 1);
            chk(rq, "miss addr", bus_addr, a);
            for (int k = 0; k < fdly; k++) begin
                @(negedge clk); #1;
                chk("R3", "hold bus before fill", bus_req, 1);
                chk("R3", "no ack before fill", cpu_ack, 0);
            end
            @(negedge clk);
            fill_valid = 1'b1; fill_data = mem[a];
            #1;
            chk(rq, "fill ack", cpu_ack, 1);
            if (!wr) chk(rq, "fill rdata", cpu_rdata, mem[a]);
            m_st[i] = wr ? 2 : 1; m_tag[i] = tg; m_dat[i] = wr ? wd : mem[a];
        end
        @(negedge clk);
        cpu_valid = 1'b0; bus_gnt = 1'b0; fill_valid = 1'b0;
        #1;
        chk(rq, "bus released", bus_req, 0);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a);
        int i = int'(a[IDX_W-1:0]);
        bit match = (m_st[i] != 0) && (m_tag[i] == a[ADDR_W-1:IDX_W]);
        bit miss  = (cmd == 2'b01) || (cmd == 2'b10);
        bit fl    = match && miss && (m_st[i] == 2);
        string rq = !(match && miss) ? "R10" : (fl ? "R9" : (cmd == 2'b10 ? "R8" : "R10"));
        @(negedge clk);
        snp_cmd = cmd; snp_addr = a;
        @(negedge clk);
        snp_cmd = 2'b00;
        #1;
        chk(rq, "abort", snp_abort, fl);
        if (fl) begin
            chk(rq, "supplied addr", snp_wb_addr, a);
            chk(rq, "supplied data", snp_wb_data, m_dat[i]);
            mem[a] = m_dat[i];
        end
        if (match && miss) begin
            if (m_st[i] == 2) m_st[i] = (cmd == 2'b01) ? 1 : 0;
            else if (cmd == 2'b10) m_st[i] = 0;
        end
    endtask

    // R8 / R10 visibility: the very next access must miss or hit as the model says
    task automatic probe_read(input string rq, input logic [ADDR_W-1:0] a, input bit exp_hit);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = a;
        #1;
        chk(rq, "probe ack", cpu_ack, exp_hit);
        @(negedge clk);
        cpu_valid = 1'b0;
        if (!exp_hit) begin
            // leave the pending request path through a full miss
            cpu_op(1'b0, a, '0, 0, 0);
        end
    endtask

    task automatic restart_case();
        logic [ADDR_W-1:0] old_a = {4'd2, 2'd1};
        logic [ADDR_W-1:0] new_a = {4'd3, 2'd1};
        logic [DATA_W-1:0] old_d;
        cpu_op(1'b1, old_a, 16'hBEEF, 0, 0);
        old_d = m_dat[1];
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = new_a;
        #1;
        chk("R12", "no ack on miss", cpu_ack, 0);
        @(negedge clk);
        snp_cmd = 2'b01; snp_addr = old_a;
        #1;
        chk("R12", "waiting req", bus_req, 1);
        @(negedge clk);
        snp_cmd = 2'b00;
        #1;
        chk("R11", "old line supplied", snp_abort, 1);
        chk("R11", "old line data kept", snp_wb_data, old_d);
        chk("R12", "req dropped on restart", bus_req, 0);
        mem[old_a] = old_d;
        m_st[1] = 1;
        @(negedge clk);
        bus_gnt = 1'b1;
        #1;
        chk("R12", "req raised again", bus_req, 1);
        @(negedge clk); #1;
        chk("R12", "no second write-back", bus_cmd, 1);
        chk("R12", "miss addr", bus_addr, new_a);
        @(negedge clk);
        fill_valid = 1'b1; fill_data = mem[new_a];
        #1;
        chk("R12", "fill ack", cpu_ack, 1);
        chk("R12", "fill data", cpu_rdata, mem[new_a]);
        m_st[1] = 1; m_tag[1] = 4'd3; m_dat[1] = mem[new_a];
        @(negedge clk);
        cpu_valid = 1'b0; bus_gnt = 1'b0; fill_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
        for (int i = 0; i < 64; i++) mem[i] = 16'hA000 ^ DATA_W'(i * 16'h0133);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "bus_cmd", bus_cmd, 0);
        chk("R1", "ack", cpu_ack, 0);
        chk("R1", "abort", snp_abort, 0);
        probe_read("R1", {4'd0, 2'd0}, 1'b0);

        cpu_op(1'b0, {4'd1, 2'd1}, '0, 2, 1);        // R3
        cpu_op(1'b0, {4'd1, 2'd1}, '0, 0, 0);        // R2
        cpu_op(1'b1, {4'd1, 2'd1}, 16'h1234, 1, 2);  // R4 upgrade
        cpu_op(1'b0, {4'd1, 2'd1}, '0, 0, 0);        // R2
        cpu_op(1'b1, {4'd1, 2'd1}, 16'h5678, 0, 0);  // R2 write hit
        cpu_op(1'b0, {4'd1, 2'd2}, '0, 0, 0);        // R3
        cpu_op(1'b0, {4'd2, 2'd2}, '0, 1, 0);        // R5
        cpu_op(1'b0, {4'd2, 2'd1}, '0, 0, 1);        // R6
        cpu_op(1'b1, {4'd3, 2'd3}, 16'h0F0F, 0, 0);  // R4
        cpu_op(1'b1, {4'd0, 2'd3}, 16'hF00D, 2, 0);  // R7
        cpu_op(1'b0, {4'd0, 2'd3}, '0, 0, 0);        // R2

        snoop(2'b10, {4'd2, 2'd2});                  // R8
        probe_read("R8", {4'd2, 2'd2}, 1'b0);
        snoop(2'b01, {4'd0, 2'd3});                  // R9 to Shared
        probe_read("R9", {4'd0, 2'd3}, 1'b1);
        cpu_op(1'b1, {4'd5, 2'd0}, 16'hCAFE, 0, 0);
        snoop(2'b11, {4'd5, 2'd0});                  // R10 write-back ignored
        snoop(2'b01, {4'd6, 2'd0});                  // R10 tag mismatch
        probe_read("R10", {4'd5, 2'd0}, 1'b1);
        snoop(2'b10, {4'd5, 2'd0});                  // R9 to Invalid
        probe_read("R9", {4'd5, 2'd0}, 1'b0);

        restart_case();                              // R11 R12

        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] a = {2'b00, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            if ($urandom_range(0, 9) < 7)
                cpu_op(1'($urandom_range(0, 1)), a, 16'($urandom), $urandom_range(0, 2), $urandom_range(0, 2));
            else
                snoop(2'($urandom_range(0, 3)), a);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule